// File: doc/BRIEF.md
# Byte-Serial Instruction Length Decoder

This block takes a variable-length instruction stream in the common desktop CISC encoding and consumes it one byte per clock. Bytes arrive over a valid/ready pair. For each instruction the block finds the final byte and pulses a completion strobe. Along with the strobe it presents the total length and the decoded operand layout: repeat and register-extension prefix flags, the opcode, the three ModR/M fields widened to four bits where an extension prefix applies, whether a scale/index/base byte was present, and the displacement and immediate sizes.

A mode input picks 32-bit or 64-bit operation. The choice matters for the 0x40–0x4F byte range. In 32-bit mode those bytes are complete one-byte instructions. In 64-bit mode they are extension prefixes whose bits widen the register numbers. Only a small opcode set is recognised. Any other byte at an opcode position raises an error strobe and resynchronises the decoder on the next byte.

A front end would use the strobes to cut a fetched byte stream into instruction boundaries and to hand the field summary to a later decode stage.

Top module: `ild_top`

## Requirements
- R1: After reset `done` and `err` are low and `in_ready` is high. A byte is consumed only in a cycle where `in_valid` is high, and cycles with `in_valid` low leave the decode untouched.
- R2: On the clock edge that accepts an instruction's final byte, `done` rises for one cycle. At that point `len` equals the count of all its bytes: prefixes, opcode, ModR/M, SIB, displacement and immediate. The other outputs hold that instruction's fields until the next byte is accepted.
- R3: Opcodes 0x99 and 0xA4 carry no ModR/M byte and end at the opcode. Opcodes 0x50–0x57 also end at the opcode, with `rm_f` = {extension B bit, opcode bits [2:0]}.
- R4: The ModR/M byte has the mode field in bits [7:6], reg in bits [5:3] and rm in bits [2:0]. Displacement size is set by the mode field: 11 gives 0 bytes, 01 gives 1 byte, 10 gives 4 bytes. Mode 00 gives 0 bytes, except that rm=101 gives 4.
- R5: A SIB byte follows the ModR/M byte exactly when mode≠11 and rm=100. When mode=00 and the SIB base field (SIB bits [2:0]) is 101, a 4-byte displacement is added.
- R6: Immediate sizes are as follows. 0x68 takes 4 and 0x6A takes 1, with no ModR/M. 0x69 and 0x81 take ModR/M plus 4. 0x6B and 0x83 take ModR/M plus 1. 0xF7 takes ModR/M plus 4 when reg is 000 or 001, and no immediate otherwise. 0xD1, 0x01, 0x03, 0x89 and 0x8B take ModR/M with no immediate.
- R7: For 0x81, 0x83, 0xF7 and 0xD1, `reg_is_ext` is high and `reg_f` = {0, reg}. For every other ModR/M opcode, `reg_f` = {extension R bit, reg}. In all ModR/M cases `rm_f` = {extension B bit, rm}.
- R8: With `mode64` low, a byte 0x40–0x4F at the opcode position is a complete one-byte instruction. It reports `rm_f` = {0, bits [2:0]} and `rex_seen` low.
- R9: With `mode64` high, a 0x40–0x4F byte is a prefix whose bit 3 is W, bit 2 is R and bit 0 is B. It sets `rex_seen` and `rex_w` = W. If two such prefixes occur, the later one wins. A 0xF3 byte after it discards it, so `rex_seen`, `rex_w` and the extension bits read 0.
- R10: A 0xF3 byte before the opcode sets `rep` and counts toward `len`.
- R11: A byte outside the set at the opcode position raises `err` together with `done`. It reports `len`=1 and `opcode` = that byte, with every other field zero and any earlier prefixes dropped. The next byte starts a new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | 1 = 64-bit operation, 0 = 32-bit |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Decoder accepts a byte (always high) |
| done | output | 1 | One-cycle strobe: an instruction ended |
| err | output | 1 | Unknown opcode, asserted with done |
| len | output | LEN_W | Instruction length in bytes |
| opcode | output | 8 | Opcode byte |
| rep | output | 1 | Repeat prefix seen |
| rex_seen | output | 1 | Register-extension prefix in force |
| rex_w | output | 1 | Operand-width bit of that prefix |
| has_modrm | output | 1 | ModR/M byte present |
| mod_f | output | 2 | ModR/M mode field |
| reg_f | output | 4 | Widened reg field or extension code |
| rm_f | output | 4 | Widened rm field or register in opcode |
| reg_is_ext | output | 1 | reg_f is an opcode extension |
| has_sib | output | 1 | SIB byte present |
| disp_sz | output | 3 | Displacement bytes (0, 1 or 4) |
| imm_sz | output | 3 | Immediate bytes (0, 1 or 4) |

## Verification
The assertions assume `mode64` stays constant from the first byte of an instruction to its final byte. They also assume an instruction never holds enough prefixes to push its length past the range of `len`. The stimulus changes `mode64` only between instructions and never places more than two prefix bytes before an opcode. It also inserts idle cycles carrying a junk byte with `in_valid` low, which the decoder must not see.

// File: rtl/ild_pkg.sv
package ild_pkg;

  typedef enum logic [1:0] {
    ST_OPC   = 2'd0,
    ST_MODRM = 2'd1,
    ST_SIB   = 2'd2,
    ST_TAIL  = 2'd3
  } ild_state_e;

  typedef struct packed {
    logic       known;
    logic       is_rep;
    logic       is_rex;
    logic       needs_modrm;
    logic       grp_ext;
    logic       grp_f7;
    logic [2:0] imm;
  } opc_info_t;

  // displacement bytes implied by a ModR/M byte
  function automatic logic [2:0] disp_of_modrm(input logic [1:0] md, input logic [2:0] rm);
    case (md)
      2'b01:   return 3'd1;
      2'b10:   return 3'd4;
      2'b00:   return (rm == 3'b101) ? 3'd4 : 3'd0;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic sib_follows(input logic [1:0] md, input logic [2:0] rm);
    return (md != 2'b11) && (rm == 3'b100);
  endfunction

  // extra displacement implied by a SIB base field
  function automatic logic [2:0] disp_of_sib(input logic [1:0] md, input logic [2:0] base);
    return (md == 2'b00 && base == 3'b101) ? 3'd4 : 3'd0;
  endfunction

endpackage

// File: rtl/ild_opclass.sv
module ild_opclass
  import ild_pkg::*;
(
  input  logic       mode64,
  input  logic [7:0] b,
  output opc_info_t  info
);

  always_comb begin
    info = '0;
    if (b inside {[8'h40:8'h4F]}) begin
      info.known  = 1'b1;
      info.is_rex = mode64;
    end else if (b inside {[8'h50:8'h57], 8'h99, 8'hA4}) begin
      info.known = 1'b1;
    end else begin
      case (b)
        8'hF3: begin info.known = 1'b1; info.is_rep = 1'b1; end
        8'h68: begin info.known = 1'b1; info.imm = 3'd4; end
        8'h6A: begin info.known = 1'b1; info.imm = 3'd1; end
        8'h69: begin info.known = 1'b1; info.needs_modrm = 1'b1; info.imm = 3'd4; end
        8'h6B: begin info.known = 1'b1; info.needs_modrm = 1'b1; info.imm = 3'd1; end
        8'h81: begin info.known = 1'b1; info.needs_modrm = 1'b1; info.grp_ext = 1'b1; info.imm = 3'd4; end
        8'h83: begin info.known = 1'b1; info.needs_modrm = 1'b1; info.grp_ext = 1'b1; info.imm = 3'd1; end
        8'hF7: begin info.known = 1'b1; info.needs_modrm = 1'b1; info.grp_ext = 1'b1; info.grp_f7 = 1'b1; end
        8'hD1: begin info.known = 1'b1; info.needs_modrm = 1'b1; info.grp_ext = 1'b1; end
        8'h01, 8'h03, 8'h89, 8'h8B: begin info.known = 1'b1; info.needs_modrm = 1'b1; end
        default: info = '0;
      endcase
    end
  end

endmodule

// File: rtl/ild_addr_eval.sv
module ild_addr_eval
  import ild_pkg::*;
(
  input  logic [1:0] cur_md,
  input  logic [2:0] cur_lo,
  input  logic [1:0] saved_md,
  output logic       need_sib,
  output logic [2:0] d_modrm,
  output logic [2:0] d_sib
);

  assign need_sib = sib_follows(cur_md, cur_lo);
  assign d_modrm  = disp_of_modrm(cur_md, cur_lo);
  assign d_sib    = disp_of_sib(saved_md, cur_lo);

endmodule

// File: rtl/ild_top.sv
module ild_top
  import ild_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode64,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic             done,
  output logic             err,
  output logic [LEN_W-1:0] len,
  output logic [7:0]       opcode,
  output logic             rep,
  output logic             rex_seen,
  output logic             rex_w,
  output logic             has_modrm,
  output logic [1:0]       mod_f,
  output logic [3:0]       reg_f,
  output logic [3:0]       rm_f,
  output logic             reg_is_ext,
  output logic             has_sib,
  output logic [2:0]       disp_sz,
  output logic [2:0]       imm_sz
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  function automatic logic [LEN_W-1:0] len_sum(input logic [LEN_W-1:0] p, input logic hm,
                                               input logic hs, input logic [2:0] d,
                                               input logic [2:0] im);
    return p + ONE + LEN_W'(hm) + LEN_W'(hs) + LEN_W'(d) + LEN_W'(im);
  endfunction

  function automatic logic [3:0] tail_of(input logic [2:0] d, input logic [2:0] im);
    return {1'b0, d} + {1'b0, im};
  endfunction

  ild_state_e       st_q;
  logic [LEN_W-1:0] cnt_q, pfx_q;
  logic [3:0]       left_q;
  logic             f7_q, ext_pend_q;
  logic             rex_r_q, rex_b_q, rex_w_q;

  opc_info_t  ci;
  logic       need_sib;
  logic [2:0] d_modrm, d_sib;

  ild_opclass u_cls (.mode64(mode64), .b(in_byte), .info(ci));

  ild_addr_eval u_addr (
    .cur_md(in_byte[7:6]), .cur_lo(in_byte[2:0]), .saved_md(mod_f),
    .need_sib(need_sib), .d_modrm(d_modrm), .d_sib(d_sib)
  );

  // named events
  wire acc     = in_valid & in_ready;
  wire fresh   = (st_q == ST_OPC) && (cnt_q == '0);
  wire bad_op  = acc && (st_q == ST_OPC) && !ci.known;
  wire rb_eff  = fresh ? 1'b0 : rex_b_q;
  wire rr_eff  = fresh ? 1'b0 : rex_r_q;
  wire [LEN_W-1:0] pfx_eff = fresh ? '0 : pfx_q;
  wire [2:0] imm_f7      = (f7_q && in_byte[5:4] == 2'b00) ? 3'd4 : imm_sz;
  wire [3:0] tail_modrm  = tail_of(d_modrm, imm_f7);
  wire [3:0] tail_sib    = tail_of(disp_sz + d_sib, imm_sz);

  assign in_ready = 1'b1;
  assign rex_w    = rex_w_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_OPC; cnt_q <= '0; pfx_q <= '0; left_q <= '0;
      f7_q <= 1'b0; ext_pend_q <= 1'b0;
      rex_r_q <= 1'b0; rex_b_q <= 1'b0; rex_w_q <= 1'b0;
      done <= 1'b0; err <= 1'b0; len <= '0; opcode <= '0;
      rep <= 1'b0; rex_seen <= 1'b0; has_modrm <= 1'b0; mod_f <= '0;
      reg_f <= '0; rm_f <= '0; reg_is_ext <= 1'b0; has_sib <= 1'b0;
      disp_sz <= '0; imm_sz <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (acc) begin
        cnt_q <= cnt_q + ONE;
        case (st_q)
          ST_OPC: begin
            if (fresh) begin
              rep <= 1'b0; rex_seen <= 1'b0; rex_w_q <= 1'b0; rex_r_q <= 1'b0; rex_b_q <= 1'b0;
              pfx_q <= '0; has_modrm <= 1'b0; mod_f <= '0; reg_f <= '0; rm_f <= '0;
              reg_is_ext <= 1'b0; has_sib <= 1'b0; disp_sz <= '0; imm_sz <= '0;
            end
            if (bad_op) begin
              err <= 1'b1; done <= 1'b1; len <= ONE; cnt_q <= '0; opcode <= in_byte;
              rep <= 1'b0; rex_seen <= 1'b0; rex_w_q <= 1'b0; rex_r_q <= 1'b0; rex_b_q <= 1'b0;
              pfx_q <= '0; has_modrm <= 1'b0; mod_f <= '0; reg_f <= '0; rm_f <= '0;
              reg_is_ext <= 1'b0; has_sib <= 1'b0; disp_sz <= '0; imm_sz <= '0;
            end else if (ci.is_rep) begin
              rep <= 1'b1; pfx_q <= pfx_eff + ONE;
              rex_seen <= 1'b0; rex_w_q <= 1'b0; rex_r_q <= 1'b0; rex_b_q <= 1'b0;
            end else if (ci.is_rex) begin
              pfx_q <= pfx_eff + ONE; rex_seen <= 1'b1;
              rex_w_q <= in_byte[3]; rex_r_q <= in_byte[2]; rex_b_q <= in_byte[0];
            end else begin
              opcode <= in_byte; imm_sz <= ci.imm;
              f7_q <= ci.grp_f7; ext_pend_q <= ci.grp_ext;
              if (ci.needs_modrm) begin
                st_q <= ST_MODRM;
              end else begin
                if (in_byte[7:4] == 4'h4 || in_byte[7:4] == 4'h5) rm_f <= {rb_eff, in_byte[2:0]};
                if (ci.imm != 3'd0) begin
                  left_q <= {1'b0, ci.imm}; st_q <= ST_TAIL;
                end else begin
                  done <= 1'b1; len <= cnt_q + ONE; cnt_q <= '0;
                end
              end
            end
          end
          ST_MODRM: begin
            has_modrm <= 1'b1; mod_f <= in_byte[7:6];
            reg_is_ext <= ext_pend_q;
            reg_f <= {ext_pend_q ? 1'b0 : rr_eff, in_byte[5:3]};
            rm_f  <= {rb_eff, in_byte[2:0]};
            imm_sz <= imm_f7;
            if (need_sib) begin
              disp_sz <= d_modrm; st_q <= ST_SIB;
            end else begin
              disp_sz <= d_modrm;
              if (tail_modrm == 4'd0) begin
                done <= 1'b1; len <= cnt_q + ONE; cnt_q <= '0; st_q <= ST_OPC;
              end else begin
                left_q <= tail_modrm; st_q <= ST_TAIL;
              end
            end
          end
          ST_SIB: begin
            has_sib <= 1'b1;
            disp_sz <= disp_sz + d_sib;
            if (tail_sib == 4'd0) begin
              done <= 1'b1; len <= cnt_q + ONE; cnt_q <= '0; st_q <= ST_OPC;
            end else begin
              left_q <= tail_sib; st_q <= ST_TAIL;
            end
          end
          default: begin
            if (left_q == 4'd1) begin
              done <= 1'b1; len <= cnt_q + ONE; cnt_q <= '0; st_q <= ST_OPC; left_q <= '0;
            end else begin
              left_q <= left_q - 4'd1;
            end
          end
        endcase
      end
    end
  end

  AST_ERR_LEN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && len == ONE && !has_modrm && !rep)); // R11
  AST_LEN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (len == len_sum(pfx_q, has_modrm, has_sib, disp_sz, imm_sz))); // R2
  AST_SIB_ESCAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && has_sib) |-> (has_modrm && mod_f != 2'b11 && rm_f[2:0] == 3'b100)); // R5
  AST_REGDIRECT_NODISP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && has_modrm && mod_f == 2'b11) |-> (disp_sz == 3'd0 && !has_sib)); // R4
  AST_EXT_NO_WIDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && reg_is_ext) |-> !reg_f[3]); // R7
  AST_NO_MODRM_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !has_modrm) |-> (!has_sib && disp_sz == 3'd0)); // R3
  AST_TAIL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TAIL) |-> (left_q != 4'd0)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!done && $stable(cnt_q))); // R1

endmodule

// File: tb/sim_ild_top.sv
`timescale 1ns/1ps
module sim_ild_top;

  typedef struct {
    bit        err;
    int        len;
    bit [7:0]  op;
    bit        rep, rexs, rexw, hm, ext, sib;
    bit [1:0]  md;
    bit [3:0]  rg, rm;
    int        disp, imm;
    string     req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode64 = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, done, err, rep, rex_seen, rex_w, has_modrm, reg_is_ext, has_sib;
  logic [3:0] len, reg_f, rm_f;
  logic [7:0] opcode;
  logic [1:0] mod_f;
  logic [2:0] disp_sz, imm_sz;

  int nchk = 0, nfail = 0, gapc = 0;
  bit finished = 0;
  exp_t expq[$];
  exp_t cur;

  always #4 clk = ~clk;

  ild_top #(.LEN_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .mode64(mode64), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .done(done), .err(err), .len(len), .opcode(opcode), .rep(rep),
    .rex_seen(rex_seen), .rex_w(rex_w), .has_modrm(has_modrm), .mod_f(mod_f),
    .reg_f(reg_f), .rm_f(rm_f), .reg_is_ext(reg_is_ext), .has_sib(has_sib),
    .disp_sz(disp_sz), .imm_sz(imm_sz)
  );

  task automatic chk(string tag, int act, int expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // reference classification, written as a table by opcode
  function automatic void op_kind(bit m64, bit [7:0] op, output bit known, output bit mrm,
                                  output bit ext, output int imm);
    known = 1; mrm = 0; ext = 0; imm = 0;
    case (op)
      8'h99, 8'hA4: ;
      8'h68: imm = 4;
      8'h6A: imm = 1;
      8'h69: begin mrm = 1; imm = 4; end
      8'h6B: begin mrm = 1; imm = 1; end
      8'h81: begin mrm = 1; ext = 1; imm = 4; end
      8'h83: begin mrm = 1; ext = 1; imm = 1; end
      8'hF7, 8'hD1: begin mrm = 1; ext = 1; end
      8'h01, 8'h03, 8'h89, 8'h8B: mrm = 1;
      default: begin
        if (op >= 8'h50 && op <= 8'h57) known = 1;
        else if (op >= 8'h40 && op <= 8'h4F && !m64) known = 1;
        else known = 0;
      end
    endcase
  endfunction

  task automatic drive(bit [7:0] b);
    if (gapc % 5 == 4) begin
      in_valid = 1'b0; in_byte = 8'h0F;   // junk while idle (R1)
      @(negedge clk);
    end
    gapc++;
    in_valid = 1'b1; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic issue(int npre, bit [7:0] p0, bit [7:0] p1, bit [7:0] op,
                       bit [7:0] mrm, bit [7:0] sb, string req);
    exp_t e;
    bit [7:0] q[$];
    bit [3:0] rx;
    bit known, hasm, ext;
    int imm;
    e = '{default: 0};
    e.req = req;
    rx = 4'h0;
    for (int i = 0; i < npre; i++) begin
      bit [7:0] p;
      p = (i == 0) ? p0 : p1;
      q.push_back(p);
      if (p == 8'hF3) begin e.rep = 1; e.rexs = 0; rx = 4'h0; end
      else begin e.rexs = 1; rx = p[3:0]; end
    end
    op_kind(mode64, op, known, hasm, ext, imm);
    q.push_back(op);
    e.op = op;
    if (!known) begin
      e = '{default: 0};
      e.err = 1; e.len = 1; e.op = op; e.req = "R11";
    end else begin
      if (!hasm) begin
        if (op[7:4] == 4'h4 || op[7:4] == 4'h5) e.rm = {rx[0], op[2:0]};
      end else begin
        q.push_back(mrm);
        e.hm = 1; e.md = mrm[7:6]; e.ext = ext;
        e.rg = ext ? {1'b0, mrm[5:3]} : {rx[2], mrm[5:3]};
        e.rm = {rx[0], mrm[2:0]};
        if (op == 8'hF7 && mrm[5:3] <= 3'd1) imm = 4;
        if (mrm[7:6] == 2'd1) e.disp = 1;
        else if (mrm[7:6] == 2'd2) e.disp = 4;
        else if (mrm[7:6] == 2'd0 && mrm[2:0] == 3'd5) e.disp = 4;
        if (mrm[7:6] != 2'd3 && mrm[2:0] == 3'd4) begin
          e.sib = 1; q.push_back(sb);
          if (mrm[7:6] == 2'd0 && sb[2:0] == 3'd5) e.disp += 4;
        end
      end
      e.imm = imm;
      for (int k = 0; k < e.disp + e.imm; k++) q.push_back(8'h11 * (k + 1));
      e.len = q.size();
      e.rexw = e.rexs & rx[3];
    end
    expq.push_back(e);
    foreach (q[i]) drive(q[i]);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL R2 unexpected done actual=1 expected=0");
      end else begin
        cur = expq.pop_front();
        chk({cur.req, " len"}, len, cur.len);
        chk("R11 err", err, cur.err);
        chk("R2 opcode", opcode, cur.op);
        chk("R10 rep", rep, cur.rep);
        chk("R9 rex_seen", rex_seen, cur.rexs);
        chk("R9 rex_w", rex_w, cur.rexw);
        chk("R4 has_modrm", has_modrm, cur.hm);
        chk("R4 mod_f", mod_f, cur.md);
        chk("R7 reg_f", reg_f, cur.rg);
        chk({cur.req, " rm_f"}, rm_f, cur.rm);
        chk("R7 reg_is_ext", reg_is_ext, cur.ext);
        chk("R5 has_sib", has_sib, cur.sib);
        chk("R4 disp_sz", disp_sz, cur.disp);
        chk("R6 imm_sz", imm_sz, cur.imm);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL R2 watchdog actual=hung expected=complete");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    bit [7:0] ops[9];
    bit [2:0] rms[4];
    bit [7:0] rexes[3];
    ops = '{8'h01, 8'h03, 8'h89, 8'h8B, 8'h69, 8'h6B, 8'h81, 8'h83, 8'hD1};
    rms = '{3'd0, 3'd3, 3'd4, 3'd5};
    rexes = '{8'h45, 8'h4A, 8'h4F};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", done, 0);
    chk("R1 err after reset", err, 0);
    chk("R1 in_ready", in_ready, 1);
    in_byte = 8'h99;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 idle no done", done, 0);
    end

    for (int m = 0; m < 2; m++) begin
      mode64 = m[0];
      issue(0, 0, 0, 8'h99, 0, 0, "R3");
      issue(0, 0, 0, 8'hA4, 0, 0, "R3");
      issue(1, 8'hF3, 0, 8'hA4, 0, 0, "R10");
      for (int r = 0; r < 8; r++) issue(0, 0, 0, 8'h50 + 8'(r), 0, 0, "R3");
      issue(0, 0, 0, 8'h68, 0, 0, "R6");
      issue(0, 0, 0, 8'h6A, 0, 0, "R6");
      issue(0, 0, 0, 8'h0F, 0, 0, "R11");
      issue(1, 8'hF3, 0, 8'hC3, 0, 0, "R11");
      issue(0, 0, 0, 8'h99, 0, 0, "R11");
      issue(0, 0, 0, 8'hF7, 8'h05, 0, "R6");
      issue(0, 0, 0, 8'hF7, 8'hC8, 0, "R6");
      issue(0, 0, 0, 8'hF7, 8'h5C, 8'h25, "R6");
      for (int o = 0; o < 9; o++)
        for (int md = 0; md < 4; md++)
          for (int ri = 0; ri < 4; ri++) begin
            issue(0, 0, 0, ops[o], {md[1:0], 3'b010, rms[ri]}, 8'h25, "R2");
            if (rms[ri] == 3'd4 && md != 3)
              issue(0, 0, 0, ops[o], {md[1:0], 3'b110, rms[ri]}, 8'h88, "R5");
          end
    end

    mode64 = 1'b0;
    issue(0, 0, 0, 8'h40, 0, 0, "R8");
    issue(0, 0, 0, 8'h4F, 0, 0, "R8");
    issue(0, 0, 0, 8'h4B, 0, 0, "R8");

    mode64 = 1'b1;
    issue(1, 8'h48, 0, 8'h89, 8'hC8, 0, "R9");
    issue(1, 8'h41, 0, 8'h53, 0, 0, "R9");
    issue(2, 8'h41, 8'h4C, 8'h89, 8'h04, 8'h24, "R9");
    issue(2, 8'h4C, 8'hF3, 8'hA4, 0, 0, "R9");
    issue(2, 8'hF3, 8'h4D, 8'h01, 8'hD9, 0, "R10");
    for (int x = 0; x < 3; x++)
      for (int o = 0; o < 9; o++)
        for (int md = 0; md < 4; md++)
          issue(1, rexes[x], 0, ops[o], {md[1:0], 3'b101, 3'b100}, 8'h35, "R7");

    repeat (6) @(negedge clk);
    chk("R2 all instructions ended", expq.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule